// File: doc/BRIEF.md
# Retry Expiration Watchdog Counters

This block watches three bus-master request paths (one on the primary bus and one for each of two card-bus targets) for a master that was told to retry and then fails to come back. Each path has its own channel. A retry-received strobe arms the channel, and the channel counts clock cycles until the matching request-reissued strobe disarms it. If the count reaches the selected limit first, the channel sets a sticky expired flag and returns to idle.

Software sees the block through one 8-bit register, read continuously on `reg_rdata` and written with a single-cycle `reg_wr` strobe. The register holds two counter enables, one for the primary-bus channel and one shared by both card-bus channels, and three expired flags that are cleared by writing 1. Two limit-select inputs choose between a short limit of 2^SHORT_LOG2 cycles and a long limit of 2^LONG_LOG2 cycles. By default these are 2^10 and 2^15. One select serves the primary-bus channel and the other serves the card-bus channels. The only reset is the global asynchronous reset.

Top module: `retry_wd_top`

## Requirements
- R1: After reset `reg_rdata` is 8'hC0: both enables (bit 7 primary, bit 6 card) are 1 and all flags are 0. Bits 4, 2 and 0 always read 0, and writes to them have no effect.
- R2: An enabled, idle channel that samples its `retry_rcvd` bit on clock edge E0 and sees no reissue sets its flag on edge E0+L, where L is its limit. The flag is visible after that edge and not earlier.
- R3: L is 2^SHORT_LOG2 when the channel's select is 1 and 2^LONG_LOG2 when it is 0. Channel 0 (primary) uses `pri_short_sel`, and channels 1 and 2 (card A, card B) use `card_short_sel`.
- R4: A `req_reissue` bit sampled on any edge up to and including E0+L disarms the channel and zeroes its count, so no expiry follows. A reissue on the terminal edge wins over expiry.
- R5: A retry sampled while the channel is armed is ignored and the original deadline stands. A retry sampled on the same edge as a reissue starts a fresh wait from zero at that edge.
- R6: Once set, a flag stays set through later reissues, retries and writes that carry 0 in its bit, until software clears it.
- R7: Writing 1 to bit 1 (primary), bit 3 (card A) or bit 5 (card B) clears that flag, and writing 0 leaves it unchanged. If the clear and a new expiry of the same channel land on the same edge, the flag ends up set.
- R8: Writing bit 7 or bit 6 sets that enable. A disabled channel holds its count at zero, stays disarmed and never expires. Disabling and re-enabling a channel abandons a wait in progress, and channels with a different enable are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Global asynchronous reset, active low |
| retry_rcvd | input | 3 | Retry-received strobes: bit 0 primary, bit 1 card A, bit 2 card B |
| req_reissue | input | 3 | Request-reissued strobes, same bit order |
| pri_short_sel | input | 1 | 1 selects the short limit for the primary-bus channel |
| card_short_sel | input | 1 | 1 selects the short limit for both card-bus channels |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read value |

## Verification
Two pairs of events can meet on one edge. In the first pair, a reissue arrives on exactly the terminal edge of a wait. The bench drives the reissue one cycle before the deadline so that it is sampled on edge E0+L, and then requires the flag to stay clear. In the second pair, a software clear lands on the same edge as a fresh expiry. The bench aligns the write strobe with that edge and requires the flag to read 1 afterwards. Both collisions are repeated for every channel, and the expiry timing is swept over every channel and both limit selections, with the other select held opposite.

// File: rtl/retry_wd_pkg.sv
package retry_wd_pkg;
  localparam int NCH         = 3;
  localparam int EN_PRI_POS  = 7;
  localparam int EN_CARD_POS = 6;
  localparam logic [7:0] STATUS_RESET = 8'hC0;
  localparam logic [7:0] WRITE_MASK   = 8'b1110_1010;

  // Register bit that carries the expired flag of channel ch.
  function automatic int flag_pos(input int ch);
    return 2 * ch + 1;
  endfunction

  function automatic logic [7:0] pack_status(input logic en_pri, input logic en_card,
                                             input logic [NCH-1:0] flags);
    logic [7:0] v;
    v = '0;
    v[EN_PRI_POS]  = en_pri;
    v[EN_CARD_POS] = en_card;
    for (int c = 0; c < NCH; c++) v[flag_pos(c)] = flags[c];
    return v;
  endfunction
endpackage

// File: rtl/retry_wd_channel.sv
module retry_wd_channel #(
  parameter int SHORT_LOG2 = 10,
  parameter int LONG_LOG2  = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic short_sel,
  input  logic retry,
  input  logic reissue,
  output logic armed,
  output logic expire
);
  localparam int CW = LONG_LOG2;

  // Count value reached on the edge before the deadline edge.
  function automatic logic [CW-1:0] last_tick(input logic use_short);
    return use_short ? CW'((1 << SHORT_LOG2) - 1) : CW'((1 << LONG_LOG2) - 1);
  endfunction

  logic [CW-1:0] cnt_q;
  logic          armed_q;
  logic          hit;

  assign hit    = enable && armed_q && !reissue && (cnt_q >= last_tick(short_sel));
  assign expire = hit;
  assign armed  = armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (!enable) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (reissue) begin
      armed_q <= retry;
      cnt_q   <= '0;
    end else if (armed_q) begin
      if (hit) begin
        armed_q <= 1'b0;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (retry) begin
      armed_q <= 1'b1;
      cnt_q   <= '0;
    end
  end
endmodule

// File: rtl/retry_wd_regs.sv
module retry_wd_regs
  import retry_wd_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr,
  input  logic [7:0]     wdata,
  input  logic [NCH-1:0] expire,
  output logic           en_pri,
  output logic           en_card,
  output logic [7:0]     rdata
);
  logic [7:0]     wr_bits;
  logic [NCH-1:0] clr_req;
  logic [NCH-1:0] flags_q;
  logic           en_pri_q, en_card_q;

  assign wr_bits = wr ? (wdata & WRITE_MASK) : 8'h00;

  for (genvar c = 0; c < NCH; c++) begin : g_flag
    assign clr_req[c] = wr_bits[flag_pos(c)];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flags_q[c] <= 1'b0;
      else if (expire[c])  flags_q[c] <= 1'b1;
      else if (clr_req[c]) flags_q[c] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_pri_q  <= STATUS_RESET[EN_PRI_POS];
      en_card_q <= STATUS_RESET[EN_CARD_POS];
    end else if (wr) begin
      en_pri_q  <= wr_bits[EN_PRI_POS];
      en_card_q <= wr_bits[EN_CARD_POS];
    end
  end

  assign en_pri  = en_pri_q;
  assign en_card = en_card_q;
  assign rdata   = pack_status(en_pri_q, en_card_q, flags_q);
endmodule

// File: rtl/retry_wd_top.sv
module retry_wd_top
  import retry_wd_pkg::*;
#(
  parameter int SHORT_LOG2 = 10,
  parameter int LONG_LOG2  = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] retry_rcvd,
  input  logic [2:0] req_reissue,
  input  logic       pri_short_sel,
  input  logic       card_short_sel,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata
);
  logic           en_pri, en_card;
  logic [NCH-1:0] chan_en, chan_short;
  logic [NCH-1:0] armed_vec;
  logic [NCH-1:0] expire_evt;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign chan_en[c]    = (c == 0) ? en_pri : en_card;
    assign chan_short[c] = (c == 0) ? pri_short_sel : card_short_sel;
    retry_wd_channel #(.SHORT_LOG2(SHORT_LOG2), .LONG_LOG2(LONG_LOG2)) i_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (chan_en[c]),
      .short_sel(chan_short[c]),
      .retry    (retry_rcvd[c]),
      .reissue  (req_reissue[c]),
      .armed    (armed_vec[c]),
      .expire   (expire_evt[c])
    );
  end

  retry_wd_regs i_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (reg_wr),
    .wdata  (reg_wdata),
    .expire (expire_evt),
    .en_pri (en_pri),
    .en_card(en_card),
    .rdata  (reg_rdata)
  );
endmodule

// File: rtl/retry_wd_checker.sv
module retry_wd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] req_reissue,
  input logic       reg_wr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic [2:0] armed_vec,
  input logic [2:0] expire_evt
);
  logic [2:0] flags_vis, clr_req;
  assign flags_vis = {reg_rdata[5], reg_rdata[3], reg_rdata[1]};
  assign clr_req   = reg_wr ? {reg_wdata[5], reg_wdata[3], reg_wdata[1]} : 3'b000;

  AST_EXPIRE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_evt != 3'b000) |=> ((flags_vis & $past(expire_evt)) == $past(expire_evt))); // R2
  AST_EXPIRE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    ((expire_evt & ~armed_vec) == 3'b000)); // R2
  AST_FLAG_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags_vis & ~$past(flags_vis) & ~$past(expire_evt)) == 3'b000)); // R2
  AST_REISSUE_BLOCKS_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    ((expire_evt & req_reissue) == 3'b000)); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(flags_vis) & ~$past(clr_req) & ~flags_vis) == 3'b000)); // R6
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_req & ~expire_evt) != 3'b000) |=> ((flags_vis & $past(clr_req & ~expire_evt)) == 3'b000)); // R7
  AST_PRI_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[7] |-> !expire_evt[0]); // R8
  AST_CARD_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[6] |-> (expire_evt[2:1] == 2'b00)); // R8
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> (reg_rdata[4] == 1'b0 && reg_rdata[2] == 1'b0 && reg_rdata[0] == 1'b0)); // R1
endmodule

bind retry_wd_top retry_wd_checker i_retry_wd_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_reissue(req_reissue),
  .reg_wr     (reg_wr),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .armed_vec  (armed_vec),
  .expire_evt (expire_evt)
);

// File: tb/test_retry_wd_top.sv
module test_retry_wd_top;
  localparam int CLK_PERIOD = 10;
  localparam int SHORT_LOG2 = 3;
  localparam int LONG_LOG2  = 6;
  localparam int LS = 1 << SHORT_LOG2;
  localparam int LL = 1 << LONG_LOG2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] retry_rcvd = '0, req_reissue = '0;
  logic       pri_short_sel = 1'b1, card_short_sel = 1'b1;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  retry_wd_top #(.SHORT_LOG2(SHORT_LOG2), .LONG_LOG2(LONG_LOG2)) i_retry_wd_top (
    .clk(clk), .rst_n(rst_n), .retry_rcvd(retry_rcvd), .req_reissue(req_reissue),
    .pri_short_sel(pri_short_sel), .card_short_sel(card_short_sel),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  function automatic logic [7:0] status(input bit ep, input bit ec, input bit [2:0] fl);
    return {ep, ec, fl[2], 1'b0, fl[1], 1'b0, fl[0], 1'b0};
  endfunction

  function automatic int lim(input int ch);
    bit s;
    s = (ch == 0) ? pri_short_sel : card_short_sel;
    return s ? LS : LL;
  endfunction

  task automatic check(input string req, input logic [7:0] exp);
    checks++;
    if (reg_rdata !== exp) begin
      failures++;
      $display("FAIL %s: reg_rdata actual=%02h expected=%02h at %0t", req, reg_rdata, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Drives strobes for exactly one sampling edge; returns after that edge.
  task automatic strobe(input logic [2:0] rt, input logic [2:0] ri);
    retry_rcvd = rt; req_reissue = ri;
    @(negedge clk);
    retry_rcvd = '0; req_reissue = '0;
  endtask

  task automatic wr(input logic [7:0] d);
    reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  initial begin
    tick(2);
    rst_n = 1'b1;
    tick(1);
    check("R1 reset value", 8'hC0);
    wr(8'hD5);
    check("R1 reserved bits ignored", 8'hC0);

    // Expiry timing sweep over channel and limit selection.
    for (int ch = 0; ch < 3; ch++) begin
      for (int s = 0; s < 2; s++) begin
        int l;
        bit [2:0] f;
        pri_short_sel  = (ch == 0) ? s[0] : ~s[0];
        card_short_sel = (ch == 0) ? ~s[0] : s[0];
        l = lim(ch);
        f = 3'b001 << ch;
        strobe(f, 3'b000);
        tick(l - 1);
        check("R2 R3 no flag before deadline", 8'hC0);
        tick(1);
        check("R2 R3 flag at deadline", status(1, 1, f));
        wr(8'hC0 | (8'h02 << (2 * ch)));
        check("R7 write-1 clears flag", 8'hC0);
      end
    end
    pri_short_sel = 1'b1; card_short_sel = 1'b1;

    // Reissue on the terminal edge wins, per channel.
    for (int ch = 0; ch < 3; ch++) begin
      bit [2:0] f;
      f = 3'b001 << ch;
      strobe(f, 3'b000);
      tick(LS - 1);
      strobe(3'b000, f);
      check("R4 reissue on terminal edge", 8'hC0);
      tick(2 * LS);
      check("R4 no later expiry", 8'hC0);
    end

    // Retry while armed is ignored.
    strobe(3'b010, 3'b000);
    tick(2);
    strobe(3'b010, 3'b000);
    tick(LS - 4);
    check("R5 armed retry ignored, before deadline", 8'hC0);
    tick(1);
    check("R5 original deadline kept", status(1, 1, 3'b010));
    wr(8'hC8);

    // Retry with reissue restarts the wait.
    strobe(3'b001, 3'b000);
    tick(3);
    strobe(3'b001, 3'b001);
    tick(LS - 1);
    check("R5 restarted wait, before new deadline", 8'hC0);
    tick(1);
    check("R5 restarted wait expires", status(1, 1, 3'b001));

    // Sticky flag.
    strobe(3'b000, 3'b001);
    tick(2 * LS);
    wr(8'hEA & ~8'h02);
    check("R6 R7 flag survives reissue and zero write", status(1, 1, 3'b001));
    wr(8'hC2);
    check("R7 cleared", 8'hC0);

    // Clear and expiry on the same edge, per channel.
    for (int ch = 0; ch < 3; ch++) begin
      bit [2:0] f;
      f = 3'b001 << ch;
      strobe(f, 3'b000);
      tick(LS - 1);
      wr(8'hC0 | (8'h02 << (2 * ch)));
      check("R7 set wins over clear", status(1, 1, f));
      wr(8'hC0 | (8'h02 << (2 * ch)));
    end

    // Enables.
    wr(8'h00);
    check("R8 both disabled", 8'h00);
    strobe(3'b111, 3'b000);
    tick(3 * LS);
    check("R8 disabled channels never expire", 8'h00);
    wr(8'hC0);
    tick(2 * LL);
    check("R8 re-enable starts idle", 8'hC0);
    wr(8'h80);
    strobe(3'b111, 3'b000);
    tick(2 * LS);
    check("R8 only primary enabled expires", status(1, 0, 3'b001));
    wr(8'hC2);
    strobe(3'b001, 3'b000);
    tick(3);
    wr(8'h40);
    wr(8'hC0);
    tick(2 * LS);
    check("R8 abandoned wait after disable", 8'hC0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule